// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block sits on the host side of a three-wire link to a delta-sigma converter. The converter has a serial data output and takes a serial clock and an active-low select. When `start_i` is pulsed, the reader pulls select low. It then watches the data line until the converter drives it low, which means the conversion has finished. If that does not happen within a set number of cycles, the reader gives up and flags an error. Once the converter is ready, the reader clocks out one 32-bit word. It samples each bit on the rising edge of its own serial clock, then releases select.

At the end of a good frame the reader registers the 24-bit conversion code, the four sub-resolution bits and the decoded status flags: channel, sign, above-range, below-range and exact zero. It raises `done_o` for one cycle with `valid_o` set. A timeout or a word whose ready bit reads high ends the frame with `err_o` set instead, and the last good result is kept. The serial clock is made from the system clock by a divide parameter, and no converter register needs setting up.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset `cs_no` is high, and `sck_o`, `done_o`, `valid_o` and `err_o` are low.
- R2: One cycle after `start_i` is seen in idle, `cs_no` is low and `sck_o` stays low while `sdo_i` is polled. The first rising edge of `sck_o` comes exactly DIV_HALF cycles after the first cycle in which `sdo_i` was sampled low.
- R3: If `sdo_i` is sampled high on TIMEOUT_CYC consecutive poll cycles, `cs_no` returns high and `done_o` pulses with `err_o` high and `valid_o` low, all TIMEOUT_CYC+1 cycles after start. No `sck_o` pulse is produced.
- R4: A frame produces exactly 32 `sck_o` pulses. Every high phase lasts DIV_HALF cycles, every low phase between pulses lasts DIV_HALF cycles, and `sck_o` is low whenever `cs_no` is high.
- R5: `sdo_i` is captured at each rising edge of `sck_o`, most significant bit first, giving word bits 31 down to 0. `result_o` is bits 27..4, `sub_lsb_o` is bits 3..0 and `chan_o` is bit 30.
- R6: `cs_no` rises in the same cycle as the 32nd falling edge of `sck_o`, which is DIV_HALF cycles after the 32nd rising edge. `done_o` is high for exactly that one cycle.
- R7: `sign_o` is bit 29 and bit 28 is the out-of-range flag. `over_o` = sign AND range flag, and `under_o` = NOT sign AND range flag. `zero_o` is high when the range flag is low and bits 27..0 are all zero.
- R8: If captured bit 31 is high, the frame ends with `err_o` high and `valid_o` low, and the result and status outputs keep their previous values.
- R9: `valid_o` goes high only at the end of a complete 32-bit frame and is never high together with `err_o`. Both flags clear when a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one frame read (taken in idle only) |
| sdo_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Converter select, active low |
| sck_o | output | 1 | Serial clock to the converter, idles low |
| done_o | output | 1 | One-cycle pulse at the end of any frame attempt |
| valid_o | output | 1 | Last frame was complete and good |
| err_o | output | 1 | Last frame timed out or read a high ready bit |
| result_o | output | RES_BITS | Conversion code |
| sub_lsb_o | output | SUB_BITS | Bits below the code resolution |
| chan_o | output | 1 | Channel bit of the last good frame |
| sign_o | output | 1 | Sign bit of the last good frame |
| over_o | output | 1 | Input above the reference |
| under_o | output | 1 | Input below zero |
| zero_o | output | 1 | Exact zero reading |

## Verification
The bench sweeps all eight combinations of the channel, sign and range bits against extreme and computed codes and sub-bit values. It also varies how long the converter keeps the line high before it is ready. If the reader shifted one bit too few or too many, the code would come out misaligned. If it sampled on the falling edge, every bit would move by one. If it clocked before seeing the line low, it would record an early rising edge. A reader that got the range decode wrong would mix up the above-range and below-range cases, or would call a zero code with sub-bits present an exact zero. The bench also times the poll timeout to the exact cycle, checks that an error frame leaves the previous result unchanged, and checks that the flags clear on the next good frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_e;

  typedef struct packed {
    logic chan;
    logic sign;
    logic over;
    logic under;
    logic zero;
  } rd_status_t;
endpackage

// File: rtl/adc_rd_sck_gen.sv
module adc_rd_sck_gen #(
  parameter int unsigned DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CW'(DIV_HALF - 1));
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= !sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  sck_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q |-> run_i);

  // R4
  half_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $rose(sck_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int unsigned FRAME_BITS = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          shift_i,
  input  logic                          bit_i,
  output logic [FRAME_BITS-1:0]         word_o,
  output logic [$clog2(FRAME_BITS+1)-1:0] count_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] word_q;
  logic [CNT_W-1:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (shift_i) begin
      word_q <= {word_q[FRAME_BITS-2:0], bit_i};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign word_o  = word_q;
  assign count_o = cnt_q;

  // R4
  extra_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (cnt_q < CNT_W'(FRAME_BITS)));

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_BITS));
endmodule

// File: rtl/adc_rd_decode.sv
module adc_rd_decode
  import adc_rd_pkg::*;
#(
  parameter int unsigned RES_BITS = 24,
  parameter int unsigned SUB_BITS = 4
) (
  input  logic [RES_BITS+SUB_BITS+3:0] word_i,
  output logic                         eoc_o,
  output logic [RES_BITS-1:0]          result_o,
  output logic [SUB_BITS-1:0]          sub_o,
  output rd_status_t                   status_o
);
  localparam int unsigned FRAME_BITS = RES_BITS + SUB_BITS + 4;
  localparam int unsigned EOC_POS    = FRAME_BITS - 1;
  localparam int unsigned CHAN_POS   = FRAME_BITS - 2;
  localparam int unsigned SIGN_POS   = FRAME_BITS - 3;
  localparam int unsigned RNG_POS    = FRAME_BITS - 4;

  logic sign, rng;

  always_comb begin
    sign           = word_i[SIGN_POS];
    rng            = word_i[RNG_POS];
    eoc_o          = word_i[EOC_POS];
    result_o       = word_i[SUB_BITS +: RES_BITS];
    sub_o          = word_i[SUB_BITS-1:0];
    status_o.chan  = word_i[CHAN_POS];
    status_o.sign  = sign;
    status_o.over  = sign && rng;
    status_o.under = !sign && rng;
    status_o.zero  = !rng && (word_i[RNG_POS-1:0] == '0);
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned RES_BITS    = 24,
  parameter int unsigned SUB_BITS    = 4,
  parameter int unsigned DIV_HALF    = 4,
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                sdo_i,
  output logic                cs_no,
  output logic                sck_o,
  output logic                done_o,
  output logic                valid_o,
  output logic                err_o,
  output logic [RES_BITS-1:0] result_o,
  output logic [SUB_BITS-1:0] sub_lsb_o,
  output logic                chan_o,
  output logic                sign_o,
  output logic                over_o,
  output logic                under_o,
  output logic                zero_o
);
  localparam int unsigned FRAME_BITS = RES_BITS + SUB_BITS + 4;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int unsigned TW         = $clog2(TIMEOUT_CYC + 1);

  rd_state_e             state_q;
  logic [TW-1:0]         tmo_q;
  logic                  done_q, valid_q, err_q;
  logic [RES_BITS-1:0]   result_q;
  logic [SUB_BITS-1:0]   sub_q;
  rd_status_t            stat_q;

  logic                  run, rise, fall;
  logic [FRAME_BITS-1:0] word;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  dec_eoc;
  logic [RES_BITS-1:0]   dec_result;
  logic [SUB_BITS-1:0]   dec_sub;
  rd_status_t            dec_stat;
  logic                  frame_end;

  assign run       = (state_q == ST_SHIFT);
  assign frame_end = run && fall && (bit_cnt == CNT_W'(FRAME_BITS));

  adc_rd_sck_gen #(.DIV_HALF(DIV_HALF)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sck_o  (sck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_rd_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_POLL),
    .shift_i (rise),
    .bit_i   (sdo_i),
    .word_o  (word),
    .count_o (bit_cnt)
  );

  adc_rd_decode #(.RES_BITS(RES_BITS), .SUB_BITS(SUB_BITS)) u_dec (
    .word_i   (word),
    .eoc_o    (dec_eoc),
    .result_o (dec_result),
    .sub_o    (dec_sub),
    .status_o (dec_stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tmo_q    <= '0;
      done_q   <= 1'b0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      result_q <= '0;
      sub_q    <= '0;
      stat_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_POLL;
            tmo_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
          end
        end
        ST_POLL: begin
          if (!sdo_i) begin
            state_q <= ST_SHIFT;
          end else if (tmo_q == TW'(TIMEOUT_CYC - 1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (frame_end) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (dec_eoc) begin
              err_q <= 1'b1;
            end else begin
              valid_q  <= 1'b1;
              result_q <= dec_result;
              sub_q    <= dec_sub;
              stat_q   <= dec_stat;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no     = (state_q == ST_IDLE);
  assign done_o    = done_q;
  assign valid_o   = valid_q;
  assign err_o     = err_q;
  assign result_o  = result_q;
  assign sub_lsb_o = sub_q;
  assign chan_o    = stat_q.chan;
  assign sign_o    = stat_q.sign;
  assign over_o    = stat_q.over;
  assign under_o   = stat_q.under;
  assign zero_o    = stat_q.zero;

  // R2
  start_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && start_i) |=> !cs_no);

  // R2
  poll_sck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL) |-> !sck_o);

  // R4
  sck_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);

  // R6
  done_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !sck_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  valid_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  // R7
  range_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot0({over_o, under_o, zero_o}));

  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $stable(result_o));
endmodule

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
  localparam int DIV = 2;
  localparam int TMO = 64;
  localparam int RB  = 24;
  localparam int SB  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  wire  sdo;
  logic cs_no, sck, done, valid, err, chan, sign, over, under, zero;
  logic [RB-1:0] result;
  logic [SB-1:0] sub;

  always #5 clk = ~clk;

  adc_frame_reader #(.RES_BITS(RB), .SUB_BITS(SB), .DIV_HALF(DIV), .TIMEOUT_CYC(TMO))
  u_adc_frame_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sdo_i(sdo),
    .cs_no(cs_no), .sck_o(sck), .done_o(done), .valid_o(valid), .err_o(err),
    .result_o(result), .sub_lsb_o(sub), .chan_o(chan), .sign_o(sign),
    .over_o(over), .under_o(under), .zero_o(zero)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // converter model and monitor
  logic [31:0] m_word = 32'hFFFF_FFFF;
  int   m_delay = 0;
  bit   m_glitch = 1'b0;
  int   m_cnt = 0;
  int   m_idx = 31;
  logic m_prev_sck = 1'b0;
  logic m_prev_cs  = 1'b1;
  int   rises = 0, falls = 0, hi_run = 0, lo_run = 0, bad_width = 0;
  int   first_rise_at = -1;
  logic last_fall_cs = 1'b0, last_fall_done = 1'b0;

  assign sdo = cs_no ? 1'b1 :
               m_glitch ? ((m_cnt == m_delay) ? 1'b0 : m_word[m_idx]) :
               ((m_cnt < m_delay) ? 1'b1 : m_word[m_idx]);

  always @(negedge clk) begin
    if (m_prev_cs && !cs_no) begin
      rises = 0; falls = 0; hi_run = 0; lo_run = 0; bad_width = 0;
      first_rise_at = -1; last_fall_cs = 1'b0; last_fall_done = 1'b0;
    end
    if (!m_prev_sck && sck) begin
      rises++;
      if (rises == 1) first_rise_at = m_cnt;
      else if (lo_run != DIV) bad_width++;
      hi_run = 1;
    end else if (m_prev_sck && !sck) begin
      falls++;
      if (hi_run != DIV) bad_width++;
      lo_run = 1;
      if (falls == 32) begin
        last_fall_cs   = cs_no;
        last_fall_done = done;
      end
    end else if (sck) hi_run++;
    else lo_run++;
    if (cs_no) begin
      m_cnt = 0;
      m_idx = 31;
    end else begin
      if (m_prev_sck && !sck) m_idx--;
      m_cnt++;
    end
    m_prev_sck = sck;
    m_prev_cs  = cs_no;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] w, input int d, input bit g, output int cyc);
    m_word = w; m_delay = d; m_glitch = g;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    cyc = 1;
    chk("R2", "cs low after start", {31'd0, cs_no}, 32'd0);
    chk("R9", "valid cleared on start", {31'd0, valid}, 32'd0);
    chk("R9", "err cleared on start", {31'd0, err}, 32'd0);
    while (!done && cyc < 5000) begin
      @(negedge clk); #1;
      cyc++;
    end
    chk("R6", "frame reached done", {31'd0, done}, 32'd1);
    chk("R6", "cs high at done", {31'd0, cs_no}, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [RB-1:0] last_res;
    logic [SB-1:0] last_sub;
    repeat (3) @(negedge clk); #1;
    // R1
    chk("R1", "cs after reset", {31'd0, cs_no}, 32'd1);
    chk("R1", "sck after reset", {31'd0, sck}, 32'd0);
    chk("R1", "done after reset", {31'd0, done}, 32'd0);
    chk("R1", "valid after reset", {31'd0, valid}, 32'd0);
    chk("R1", "err after reset", {31'd0, err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;

    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 8; k++) begin
        logic [RB-1:0] code;
        logic [SB-1:0] sb;
        logic [31:0]   w;
        int            d;
        logic          e_sign, e_rng;
        case (k % 4)
          0: code = '0;
          1: code = {RB{1'b1}};
          2: code = 24'h80_0000;
          default: code = RB'((c * 37 + k) * 32'h0001_2345);
        endcase
        sb     = (k >= 4) ? SB'(c + k) : '0;
        e_sign = c[1];
        e_rng  = c[0];
        w      = {1'b0, c[2], e_sign, e_rng, code, sb};
        d      = (c + k) % 5;
        run_frame(w, d, 1'b0, cyc);
        // R4 pulse count and widths
        chk("R4", "sck pulse count", rises, 32);
        chk("R4", "sck half widths", bad_width, 0);
        chk("R2", "first rise after ready", first_rise_at, ((d > 1) ? d : 1) + DIV);
        chk("R6", "cs rises with last fall", {31'd0, last_fall_cs}, 32'd1);
        chk("R6", "done with last fall", {31'd0, last_fall_done}, 32'd1);
        chk("R9", "valid after full frame", {31'd0, valid}, 32'd1);
        chk("R9", "no err on good frame", {31'd0, err}, 32'd0);
        chk("R5", "result", {8'd0, result}, {8'd0, code});
        chk("R5", "sub lsbs", {28'd0, sub}, {28'd0, sb});
        chk("R5", "channel", {31'd0, chan}, {31'd0, c[2]});
        chk("R7", "sign", {31'd0, sign}, {31'd0, e_sign});
        chk("R7", "over", {31'd0, over}, {31'd0, e_sign & e_rng});
        chk("R7", "under", {31'd0, under}, {31'd0, !e_sign & e_rng});
        chk("R7", "zero", {31'd0, zero},
            {31'd0, (!e_rng && code == '0 && sb == '0)});
        @(negedge clk); #1;
        chk("R6", "done single cycle", {31'd0, done}, 32'd0);
        chk("R4", "sck low while idle", {31'd0, sck}, 32'd0);
        last_res = code;
        last_sub = sb;
      end
    end

    // R8 ready bit reads high in the captured word
    run_frame({1'b1, 3'b011, 24'h12_3456, 4'h5}, 3, 1'b1, cyc);
    chk("R8", "eoc high err", {31'd0, err}, 32'd1);
    chk("R8", "eoc high not valid", {31'd0, valid}, 32'd0);
    chk("R8", "result retained", {8'd0, result}, {8'd0, last_res});
    chk("R8", "sub retained", {28'd0, sub}, {28'd0, last_sub});
    chk("R4", "pulses on eoc frame", rises, 32);
    @(negedge clk); #1;

    // R3 poll timeout
    run_frame({1'b0, 3'b010, 24'hAB_CDEF, 4'h1}, 100000, 1'b0, cyc);
    chk("R3", "timeout cycle", cyc, TMO + 1);
    chk("R3", "timeout err", {31'd0, err}, 32'd1);
    chk("R3", "timeout not valid", {31'd0, valid}, 32'd0);
    chk("R3", "no sck on timeout", rises, 0);
    chk("R3", "result retained", {8'd0, result}, {8'd0, last_res});
    @(negedge clk); #1;

    // R9 recovery after errors
    run_frame({1'b0, 3'b110, 24'h00_0F0F, 4'h3}, 2, 1'b0, cyc);
    chk("R9", "valid after recovery", {31'd0, valid}, 32'd1);
    chk("R9", "err cleared", {31'd0, err}, 32'd0);
    chk("R5", "result after recovery", {8'd0, result}, 32'h0000_0F0F);
    chk("R7", "over after recovery", {31'd0, over}, 32'd0);
    chk("R7", "under after recovery", {31'd0, under}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule